// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block watches three digitised supply-status flags from external comparators. One flag says the supply is below the upper trip point. One says it is below the lower trip point. One says it is below the battery-switch threshold. From these flags it drives three outputs for a battery-backed static memory: a power-fail interrupt, a deselect/write-protect signal and a battery-select signal.

When the supply starts to sag, the interrupt is raised at once. This gives the host a short, bounded warning window before the memory deselects itself. While deselected, the memory is write-protected: its outputs float and its inputs are ignored. If the supply crosses the lower trip point, protection is applied at once and no warning window is granted. After a supply return, and after reset (taken as power-up), protection and the interrupt are released together. That release happens only once the supply has stayed above the upper trip point for a full recovery interval.

A free-running prescaler, clocked from the internal clock, makes a one-microsecond strobe. Both delays are counted in these strobes. The warning delay is a parameter, and a build-time check holds it between 10 and 40 microseconds. The recovery time is also a parameter.

Top module: `pwr_guard`

## Requirements
- R1: During and straight after reset, `irq_pull_low`, `mem_deselect` and `bat_select` are all 1. The block treats the supply as failed until the flags have been seen as healthy.
- R2: In normal operation, if only `sup_below_hi` rises, `irq_pull_low` goes to 1 exactly 3 clock cycles later (two synchroniser stages plus the state register). `mem_deselect` stays 0 at that point.
- R3: After the interrupt of R2, `mem_deselect` goes to 1 after exactly ARM_DELAY_US microsecond strobes. With a strobe every TICKS_PER_US cycles, it is still 0 at cycle 3+(ARM_DELAY_US-1)*TICKS_PER_US after the flag change and is 1 at cycle 3+ARM_DELAY_US*TICKS_PER_US.
- R4: If `sup_below_lo` is 1, `mem_deselect` and `irq_pull_low` are both 1 within 3 cycles, with no warning delay, from any state.
- R5: The flag combinations below-lower-but-not-below-upper, and below-battery-alone, are handled as below the lower trip point. Protection is therefore immediate.
- R6: `bat_select` equals the battery-switch flag, delayed by 3 cycles, in both directions.
- R7: Once all flags are 0, `mem_deselect` and `irq_pull_low` fall together after RECOVER_US strobes. They are still 1 at cycle 3+(RECOVER_US-1)*TICKS_PER_US and are 0 at cycle 3+RECOVER_US*TICKS_PER_US after the flags clear.
- R8: If any flag is set again before recovery completes, recovery is abandoned and protection stays in force. The full recovery interval restarts from the next time all flags are 0.
- R9: Once the warning window has started, the supply returning above the upper trip point does not cancel it. Deselect still follows at the R3 time, and the release then goes through recovery.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running internal clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| sup_below_hi | input | 1 | Comparator flag: supply below upper trip point (asynchronous) |
| sup_below_lo | input | 1 | Comparator flag: supply below lower trip point (asynchronous) |
| sup_below_bat | input | 1 | Comparator flag: supply below battery-switch threshold (asynchronous) |
| irq_pull_low | output | 1 | 1 = pull the open-drain interrupt line low; 0 = release it |
| mem_deselect | output | 1 | 1 = memory deselected and write-protected |
| bat_select | output | 1 | 1 = memory powered from the battery |

## Verification
Every flag change reaches the outputs on the third rising edge after it is driven, so the bench pushes two expectations for each change. One is the old value at cycle +2, to show nothing moved early. The other is the new value at cycle +3. The timed releases and the timed deselect depend on the prescaler phase, so their exact cycle is not known. Each is bracketed by a pair of expectations: the still-old value one strobe period before the nominal end, and the new value at the latest cycle it may arrive. The monitor compares each queued item on the falling edge of its due cycle, half a period away from the edge that updates the state.

// File: rtl/pwr_pkg.sv
// Package: shared types for the power-fail supervisor.
// Assumes: nothing; pure type definitions.
package pwr_pkg;

    // Decoded supply condition, ordered by severity.
    typedef enum logic [1:0] {
        LVL_OK   = 2'd0,  // above upper trip point
        LVL_WARN = 2'd1,  // below upper, above lower
        LVL_LOW  = 2'd2,  // below lower trip point
        LVL_BAT  = 2'd3   // below battery-switch threshold
    } lvl_t;

    // Supervisor sequence states.
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,  // normal operation
        ST_ALERT   = 2'd1,  // interrupt raised, deselect pending
        ST_HOLD    = 2'd2,  // deselected, waiting for good supply
        ST_RECOVER = 2'd3   // supply good, timing recovery
    } st_t;

endpackage

// File: rtl/pwr_sync.sv
// Module: pwr_sync
// Two-stage synchroniser for a bundle of asynchronous flags.
// Assumes: each flag is quasi-static compared with the clock, so bits
// may be resolved independently; RST_VAL is the value held in reset.
module pwr_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] meta_q;

    // Capture the asynchronous flags through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_sync <= RST_VAL;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end

endmodule

// File: rtl/pwr_level.sv
// Module: pwr_level
// Maps the three synchronised comparator flags to one severity level.
// Assumes: flag bit order {bat, lo, hi}. An inconsistent combination is
// resolved to the most severe flag that is set, so a lower-threshold
// flag without the upper one still counts as below the lower point.
module pwr_level
    import pwr_pkg::*;
(
    input  logic [2:0] flags_i,   // {below_bat, below_lo, below_hi}
    output lvl_t       lvl_o
);

    // Priority decode: the most severe flag that is set wins.
    always_comb begin
        if (flags_i[2])      lvl_o = LVL_BAT;
        else if (flags_i[1]) lvl_o = LVL_LOW;
        else if (flags_i[0]) lvl_o = LVL_WARN;
        else                 lvl_o = LVL_OK;
    end

endmodule

// File: rtl/pwr_tick.sv
// Module: pwr_tick
// Free-running prescaler producing a one-cycle strobe every DIV clocks
// (one microsecond when DIV equals the clock rate in MHz).
// Assumes: DIV >= 2.
module pwr_tick #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    localparam int TW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [TW-1:0] LAST = TW'(DIV - 1);

    logic [TW-1:0] div_q;

    assign tick_o = (div_q == LAST);

    // Count clocks modulo DIV.
    always_ff @(posedge clk) begin
        if (!rst_n)      div_q <= '0;
        else if (tick_o) div_q <= '0;
        else             div_q <= div_q + 1'b1;
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R3

endmodule

// File: rtl/pwr_seq.sv
// Module: pwr_seq
// Power-fail sequence controller. Raises the interrupt as soon as the
// supply leaves the good band, deselects the memory after ARM_US strobes
// (or at once below the lower point), and releases both only after the
// supply has been good for REC_US strobes without a break.
// Assumes: tick_i is a single-cycle strobe; lvl_i is already synchronous.
module pwr_seq
    import pwr_pkg::*;
#(
    parameter int ARM_US = 25,
    parameter int REC_US = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  lvl_t lvl_i,
    output logic irq_o,
    output logic desel_o
);

    localparam int MAXC = ((ARM_US > REC_US) ? ARM_US : REC_US) + 1;
    localparam int CW   = $clog2(MAXC);
    localparam logic [CW-1:0] ARM_LAST = CW'(ARM_US - 1);
    localparam logic [CW-1:0] REC_LAST = CW'(REC_US - 1);

    st_t           st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          sev_low;

    assign sev_low = (lvl_i == LVL_LOW) || (lvl_i == LVL_BAT);

    // Next-state and strobe-counter logic.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_RUN: begin
                cnt_d = '0;
                if (sev_low)                st_d = ST_HOLD;
                else if (lvl_i == LVL_WARN) st_d = ST_ALERT;
            end
            ST_ALERT: begin
                if (sev_low) begin
                    st_d  = ST_HOLD;
                    cnt_d = '0;
                end else if (tick_i) begin
                    if (cnt_q == ARM_LAST) begin
                        st_d  = ST_HOLD;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                cnt_d = '0;
                if (lvl_i == LVL_OK) st_d = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (lvl_i != LVL_OK) begin
                    st_d  = ST_HOLD;
                    cnt_d = '0;
                end else if (tick_i) begin
                    if (cnt_q == REC_LAST) begin
                        st_d  = ST_RUN;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                st_d  = ST_HOLD;
                cnt_d = '0;
            end
        endcase
    end

    // State and counter registers; reset starts protected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_HOLD;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Output decode from state.
    assign irq_o   = (st_q != ST_RUN);
    assign desel_o = (st_q == ST_HOLD) || (st_q == ST_RECOVER);

    AST_LOW_FORCES_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        sev_low |=> (desel_o && irq_o)); // R4

    AST_ALERT_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ALERT) |-> (cnt_q < CW'(ARM_US))); // R3

    AST_DESEL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(desel_o) |-> ($past(sev_low) ||
                            ($past(st_q == ST_ALERT) && $past(tick_i)))); // R3

    AST_RELEASE_ONLY_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(desel_o) |-> ($past(lvl_i == LVL_OK) && !irq_o)); // R7

    AST_BAD_BLOCKS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (desel_o && lvl_i != LVL_OK) |=> desel_o); // R8

endmodule

// File: rtl/pwr_guard.sv
// Module: pwr_guard (top)
// Power-fail write-protect supervisor: synchronises the comparator
// flags, decodes the supply level, times the warning and recovery
// windows, and drives interrupt, deselect and battery select.
// Assumes: TICKS_PER_US is the clock rate in MHz; the interrupt pad is
// open-drain, so irq_pull_low only ever enables a pull to ground.
module pwr_guard
    import pwr_pkg::*;
#(
    parameter int TICKS_PER_US = 8,
    parameter int ARM_DELAY_US = 25,
    parameter int RECOVER_US   = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_below_hi,
    input  logic sup_below_lo,
    input  logic sup_below_bat,
    output logic irq_pull_low,
    output logic mem_deselect,
    output logic bat_select
);

    // Build-time range check on the warning window.
    generate
        if (ARM_DELAY_US < 10 || ARM_DELAY_US > 40) begin : g_bad_arm
            $error("ARM_DELAY_US must lie within 10..40");
        end
    endgenerate

    logic [2:0] flags_s;
    lvl_t       lvl;
    logic       us_tick;
    logic       bat_q;

    pwr_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({sup_below_bat, sup_below_lo, sup_below_hi}),
        .q_sync  (flags_s)
    );

    pwr_level u_level (
        .flags_i (flags_s),
        .lvl_o   (lvl)
    );

    pwr_tick #(.DIV(TICKS_PER_US)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (us_tick)
    );

    pwr_seq #(.ARM_US(ARM_DELAY_US), .REC_US(RECOVER_US)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (us_tick),
        .lvl_i   (lvl),
        .irq_o   (irq_pull_low),
        .desel_o (mem_deselect)
    );

    // Battery select follows the synchronised battery-switch flag.
    always_ff @(posedge clk) begin
        if (!rst_n) bat_q <= 1'b1;
        else        bat_q <= (lvl == LVL_BAT);
    end

    assign bat_select = bat_q;

    AST_BAT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        flags_s[2] |=> bat_select); // R6

    AST_BAT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_s[2] |=> !bat_select); // R6

    AST_DESEL_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_deselect && !$past(mem_deselect) && $past(lvl) == LVL_WARN)
            |-> $past(irq_pull_low)); // R2

endmodule

// File: tb/sim_pwr_guard.sv
// Scoreboard bench for pwr_guard: driver tasks queue expected outputs
// with a due cycle; a monitor pops and compares them on falling edges.
module sim_pwr_guard;

    localparam int M   = 4;
    localparam int ARM = 25;
    localparam int REC = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi = 1'b0, lo = 1'b0, bat = 1'b0;
    logic irq, desel, bsel;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        int    due;
        bit    irq;
        bit    des;
        bit    bat;
        string req;
    } exp_t;

    exp_t sbq[$];

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    pwr_guard #(.TICKS_PER_US(M), .ARM_DELAY_US(ARM), .RECOVER_US(REC)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .sup_below_hi (hi),
        .sup_below_lo (lo),
        .sup_below_bat(bat),
        .irq_pull_low (irq),
        .mem_deselect (desel),
        .bat_select   (bsel)
    );

    // Queue an expectation due dt cycles from now.
    task automatic expect_in(input int dt, input bit i, input bit d,
                             input bit b, input string r);
        exp_t e;
        e.due = cyc + dt; e.irq = i; e.des = d; e.bat = b; e.req = r;
        sbq.push_back(e);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare due expectations away from the active edge.
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            exp_t e;
            e = sbq.pop_front();
            n_chk++;
            if ({irq, desel, bsel} !== {e.irq, e.des, e.bat}) begin
                n_bad++;
                $display("FAIL %s cycle %0d: got irq/des/bat=%b%b%b expected %b%b%b",
                         e.req, cyc, irq, desel, bsel, e.irq, e.des, e.bat);
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hung run expected completion");
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        expect_in(1, 1, 1, 1, "R1");            // reset state
        wait_cyc(3);
        rst_n = 1'b1;                           // release with good supply
        expect_in(2, 1, 1, 1, "R1");
        expect_in(3, 1, 1, 0, "R6");
        expect_in(3 + (REC-1)*M, 1, 1, 0, "R7");
        expect_in(3 + REC*M,     0, 0, 0, "R7");
        wait_cyc(REC*M + 10);

        // R2 / R3: upper trip only.
        hi = 1'b1;
        expect_in(2, 0, 0, 0, "R2");
        expect_in(3, 1, 0, 0, "R2");
        expect_in(3 + (ARM-1)*M, 1, 0, 0, "R3");
        expect_in(3 + ARM*M,     1, 1, 0, "R3");
        wait_cyc(ARM*M + 10);

        // R7: supply returns.
        hi = 1'b0;
        expect_in(3, 1, 1, 0, "R7");
        expect_in(3 + (REC-1)*M, 1, 1, 0, "R7");
        expect_in(3 + REC*M,     0, 0, 0, "R7");
        wait_cyc(REC*M + 10);

        // R4: straight to lower trip from normal operation.
        hi = 1'b1; lo = 1'b1;
        expect_in(2, 0, 0, 0, "R4");
        expect_in(3, 1, 1, 0, "R4");
        wait_cyc(10);

        // R6: battery switch both ways.
        bat = 1'b1;
        expect_in(2, 1, 1, 0, "R6");
        expect_in(3, 1, 1, 1, "R6");
        wait_cyc(10);
        bat = 1'b0;
        expect_in(2, 1, 1, 1, "R6");
        expect_in(3, 1, 1, 0, "R6");
        wait_cyc(10);

        // R8: recovery interrupted and restarted.
        begin
            int c_rel;
            hi = 1'b0; lo = 1'b0;
            c_rel = cyc;
            wait_cyc(100);
            hi = 1'b1;
            expect_in(3, 1, 1, 0, "R8");
            wait_cyc(10);
            hi = 1'b0;
            expect_in(c_rel + 3 + REC*M - cyc, 1, 1, 0, "R8");
            expect_in(3 + (REC-1)*M, 1, 1, 0, "R8");
            expect_in(3 + REC*M,     0, 0, 0, "R8");
            wait_cyc(REC*M + 10);
        end

        // R5: inconsistent combination, lower without upper.
        lo = 1'b1;
        expect_in(2, 0, 0, 0, "R5");
        expect_in(3, 1, 1, 0, "R5");
        wait_cyc(10);
        lo = 1'b0;
        expect_in(3 + REC*M + 2, 0, 0, 0, "R5");
        wait_cyc(REC*M + 10);

        // R5: battery flag alone.
        bat = 1'b1;
        expect_in(3, 1, 1, 1, "R5");
        wait_cyc(10);
        bat = 1'b0;
        expect_in(3 + REC*M + 2, 0, 0, 0, "R5");
        wait_cyc(REC*M + 10);

        // R9: supply recovers during the warning window.
        hi = 1'b1;
        expect_in(3, 1, 0, 0, "R9");
        expect_in(3 + (ARM-1)*M, 1, 0, 0, "R9");
        expect_in(3 + ARM*M,     1, 1, 0, "R9");
        wait_cyc(20);
        hi = 1'b0;
        wait_cyc(ARM*M);
        expect_in(REC*M + 10, 0, 0, 0, "R9");
        wait_cyc(REC*M + 20);

        done = 1'b1;
        finish_run();
    end

endmodule